// File: doc/BRIEF.md
# Multiple Register Transfer Sequencer

The block moves a selected subset of sixteen 32-bit registers to or from memory, one register per bus access. A pulse on `start_i` samples a 16-bit selection mask, the operand size, the transfer direction, an addressing-mode code, a 3-bit base-register field and a start address. Effective-address calculation happens outside the block. The sequencer walks the mask and skips clear bits. For each selected register it reads the register file and issues a store, or issues a load and writes the sign-extended or full result back. It steps the address by the operand size.

There are two special modes. In predecrement mode, mode code 4, the block stores registers. The mask is reinterpreted, the walk runs in reverse register order, and the address drops before each store. In postincrement mode, mode code 3, the block loads registers. In both modes the final address is written to the base address register. Alongside the transfers the block builds a cycle count from a mode-dependent base cost plus a per-register cost. It announces completion with a one-cycle `done_o` pulse.

Register index encoding on the register-file ports: 0–7 are data registers D0–D7 and 8–15 are address registers A0–A7. Memory is byte addressed. `mem_long_o` high marks a 32-bit access.

Top module: `mreg_seq`

## Requirements
- R1: Outside predecrement mode, mask bit i selects register index i (bits 0–7 → D0–D7, bits 8–15 → A0–A7). Transfers go in ascending bit order, the first at the start address and each next one at the previous address plus the step.
- R2: `size_i` = 0 selects 16-bit words with a step of 2, and `size_i` = 1 selects 32-bit longs with a step of 4. A word store places the register's low 16 bits on `mem_wdata_o[15:0]` with zeros above.
- R3: A word load writes `mem_rdata_i[15:0]` sign-extended to 32 bits and ignores `mem_rdata_i[31:16]`. A long load writes all 32 bits.
- R4: In predecrement mode (`load_i` = 0, `mode_i` = 4), mask bit i selects register index 15−i (bits 0–7 → A7..A0, bits 8–15 → D7..D0). Bits are taken in ascending order, and each store's address is the previous address minus the step.
- R5: After a predecrement transfer, the lowest store address is written to address register A[`ea_reg_i`] (register index 8+`ea_reg_i`).
- R6: In postincrement mode (`load_i` = 1, `mode_i` = 3), the address that follows the last load is written to A[`ea_reg_i`]. This write-back overrides a value loaded into the same register by the transfer.
- R7: Each transferred register adds 4 cycles (word) or 8 cycles (long) to `cycles_o`. `cycles_o` holds its final value until the next start.
- R8: Load base cost by mode: 2 or 3 → 12, 5 → 16, 6 → 18, 7 with `ea_reg_i` 0 (absolute short) → 16, 7 with `ea_reg_i` 1 (absolute long) → 20.
- R9: Store base cost by mode: 2 or 4 → 8, 5 → 12, 6 → 14, 7/0 → 12, 7/1 → 16.
- R10: Clear mask bits cause no access and no cost. An all-zero mask produces no bus request, yields only the base cost and leaves the base register unchanged.
- R11: `mem_req_o`, `mem_addr_o`, `mem_we_o`, `mem_long_o` and `mem_wdata_o` stay stable while a request waits for `mem_ack_i`.
- R12: `done_o` is a single-cycle pulse following the last access and any write-back. `busy_o` is high from the cycle after start until that pulse ends, and no request is raised while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| mask_i | input | 16 | Register selection mask |
| size_i | input | 1 | 0 word, 1 long |
| load_i | input | 1 | 1 memory to registers, 0 registers to memory |
| mode_i | input | 3 | Addressing-mode code |
| ea_reg_i | input | 3 | Base register number / absolute sub-mode |
| addr_i | input | AW | Start address |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | DW | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | DW | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (store) |
| mem_long_o | output | 1 | 32-bit access when high |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Store data |
| mem_ack_i | input | 1 | Access accepted / load data valid |
| mem_rdata_i | input | DW | Load data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| cycles_o | output | CW | Accumulated cycle count |

## Verification
In postincrement mode, the register loaded by the last access and the base-register write-back can target the same register index within consecutive cycles. The bench provokes this by loading a mask that includes the base register itself. It judges the result at the register file after `done_o`: the register must hold the advanced address, not the loaded word. A second pairing is the last acknowledged access, which updates the address and the cycle count, and the decision to write back or finish. The bench judges it by comparing the final base-register value and `cycles_o` against values worked out from the mask, size and mode.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
  localparam int REG_N = 16;
  localparam int IDX_W = $clog2(REG_N);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WB,
    ST_FIN
  } mreg_state_e;
endpackage

// File: rtl/mreg_pick.sv
module mreg_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    hit_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mreg_cost.sv
module mreg_cost #(
  parameter int BW = 8
) (
  input  logic          load_i,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    sub_i,
  output logic [BW-1:0] cost_o
);
  always_comb begin
    cost_o = '0;
    if (load_i) begin
      unique case (mode_i)
        3'd2, 3'd3: cost_o = BW'(12);
        3'd5:       cost_o = BW'(16);
        3'd6:       cost_o = BW'(18);
        3'd7:       cost_o = (sub_i == 3'd0) ? BW'(16) : (sub_i == 3'd1) ? BW'(20) : '0;
        default:    cost_o = '0;
      endcase
    end else begin
      unique case (mode_i)
        3'd2, 3'd4: cost_o = BW'(8);
        3'd5:       cost_o = BW'(12);
        3'd6:       cost_o = BW'(14);
        3'd7:       cost_o = (sub_i == 3'd0) ? BW'(12) : (sub_i == 3'd1) ? BW'(16) : '0;
        default:    cost_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mreg_seq.sv
module mreg_seq
  import mreg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [REG_N-1:0]     mask_i,
  input  logic                 size_i,
  input  logic                 load_i,
  input  logic [2:0]           mode_i,
  input  logic [2:0]           ea_reg_i,
  input  logic [AW-1:0]        addr_i,
  output logic [IDX_W-1:0]     rf_raddr_o,
  input  logic [DW-1:0]        rf_rdata_i,
  output logic                 rf_we_o,
  output logic [IDX_W-1:0]     rf_waddr_o,
  output logic [DW-1:0]        rf_wdata_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic                 mem_long_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [DW-1:0]        mem_rdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [CW-1:0]        cycles_o
);
  localparam int HW = DW / 2;
  localparam int BW = 8;

  mreg_state_e          state_q;
  logic [REG_N-1:0]     rem_q;
  logic                 any_q, long_q, load_q;
  logic [2:0]           mode_q, base_q;
  logic [AW-1:0]        addr_q;
  logic [CW-1:0]        cyc_q;

  logic                 hit;
  logic [IDX_W-1:0]     bit_idx, reg_idx;
  logic                 predec, postinc, need_wb, xfer, fire;
  logic [AW-1:0]        step, acc_addr;
  logic [BW-1:0]        base_cost;

  mreg_pick #(.N(REG_N), .IW(IDX_W)) u_pick (
    .vec_i (rem_q),
    .hit_o (hit),
    .idx_o (bit_idx)
  );

  mreg_cost #(.BW(BW)) u_cost (
    .load_i (load_i),
    .mode_i (mode_i),
    .sub_i  (ea_reg_i),
    .cost_o (base_cost)
  );

  assign predec   = !load_q && (mode_q == 3'd4);
  assign postinc  = load_q && (mode_q == 3'd3);
  assign need_wb  = (predec || postinc) && any_q;
  assign reg_idx  = predec ? ~bit_idx : bit_idx;
  assign step     = long_q ? AW'(4) : AW'(2);
  assign acc_addr = predec ? addr_q - step : addr_q;
  assign xfer     = (state_q == ST_RUN) && hit;
  assign fire     = xfer && mem_ack_i;

  assign mem_req_o   = xfer;
  assign mem_we_o    = xfer && !load_q;
  assign mem_long_o  = long_q;
  assign mem_addr_o  = acc_addr;
  assign rf_raddr_o  = reg_idx;
  assign mem_wdata_o = long_q ? rf_rdata_i : {{HW{1'b0}}, rf_rdata_i[HW-1:0]};

  always_comb begin
    rf_we_o    = 1'b0;
    rf_waddr_o = reg_idx;
    rf_wdata_o = long_q ? mem_rdata_i : {{HW{mem_rdata_i[HW-1]}}, mem_rdata_i[HW-1:0]};
    if (state_q == ST_WB) begin
      rf_we_o    = 1'b1;
      rf_waddr_o = {1'b1, base_q};
      rf_wdata_o = DW'(addr_q);
    end else if (fire && load_q) begin
      rf_we_o = 1'b1;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign cycles_o = cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      any_q   <= 1'b0;
      long_q  <= 1'b0;
      load_q  <= 1'b0;
      mode_q  <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      cyc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          rem_q   <= mask_i;
          any_q   <= |mask_i;
          long_q  <= size_i;
          load_q  <= load_i;
          mode_q  <= mode_i;
          base_q  <= ea_reg_i;
          addr_q  <= addr_i;
          cyc_q   <= CW'(base_cost);
        end
        ST_RUN: begin
          if (!hit) begin
            state_q <= need_wb ? ST_WB : ST_FIN;
          end else if (mem_ack_i) begin
            rem_q[bit_idx] <= 1'b0;
            addr_q         <= predec ? acc_addr : addr_q + step;
            cyc_q          <= cyc_q + (long_q ? CW'(8) : CW'(4));
          end
        end
        ST_WB:   state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mreg_seq_chk.sv
module mreg_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_long_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          rf_we_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] cycles_o
);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                               && $stable(mem_long_o) && $stable(mem_wdata_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !rf_we_o && !done_o);

  // R7
  cyc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(cycles_o));

  // R3
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !mem_we_o);
endmodule

bind mreg_seq mreg_seq_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_long_o  (mem_long_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .rf_we_o     (rf_we_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cycles_o    (cycles_o)
);

// File: tb/mreg_seq_bench.sv
module mreg_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        size_i = 1'b0, load_i = 1'b0;
  logic [2:0]  mode_i = '0, ea_reg_i = '0;
  logic [31:0] addr_i = '0;
  logic [3:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o;
  logic        mem_req_o, mem_we_o, mem_long_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o;
  logic [15:0] cycles_o;

  int n_chk = 0, n_bad = 0;
  int n_acc = 0;
  logic [31:0] first_addr;
  logic [31:0] rf [16];
  logic [7:0]  mem [256];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mreg_seq u_mreg_seq (.*);

  assign rf_rdata_i = rf[rf_raddr_o];

  always @(posedge clk_i) if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;

  // memory model: ack one cycle after request seen, big-endian bytes
  always @(negedge clk_i) begin
    if (mem_ack_i) mem_ack_i <= 1'b0;
    else if (mem_req_o) begin
      automatic logic [7:0] a = mem_addr_o[7:0];
      if (n_acc == 0) first_addr = mem_addr_o;
      n_acc++;
      if (mem_we_o) begin
        if (mem_long_o) begin
          mem[a] <= mem_wdata_o[31:24]; mem[a+8'd1] <= mem_wdata_o[23:16];
          mem[a+8'd2] <= mem_wdata_o[15:8]; mem[a+8'd3] <= mem_wdata_o[7:0];
        end else begin
          mem[a] <= mem_wdata_o[15:8]; mem[a+8'd1] <= mem_wdata_o[7:0];
        end
      end else if (mem_long_o)
        mem_rdata_i <= {mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]};
      else
        mem_rdata_i <= {16'hDEAD, mem[a], mem[a+8'd1]};
      mem_ack_i <= 1'b1;
    end
  end

  function automatic logic [31:0] rd_l(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction
  function automatic logic [15:0] rd_w(input int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic init_state();
    for (int i = 0; i < 16; i++) rf[i] = {8'hC0, 8'(i), 16'(i * 16'h1111)};
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic run(input logic [15:0] m, input logic sz, input logic ld,
                     input logic [2:0] md, input logic [2:0] er, input logic [31:0] ad);
    int t;
    @(negedge clk_i);
    n_acc = 0;
    mask_i = m; size_i = sz; load_i = ld; mode_i = md; ea_reg_i = er; addr_i = ad;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 200) begin @(negedge clk_i); t++; end
    check("R12 done seen", {31'b0, done_o}, 32'd1);
    @(negedge clk_i);
    check("R12 done single pulse", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    check("R12 reset busy", {31'b0, busy_o}, 32'd0);
    check("R12 reset done", {31'b0, done_o}, 32'd0);
    check("R11 reset req", {31'b0, mem_req_o}, 32'd0);
    check("R7 reset cycles", {16'b0, cycles_o}, 32'd0);
  endtask

  task automatic t_store_word_asc();
    init_state();
    run(16'h0103, 1'b0, 1'b0, 3'd2, 3'd0, 32'h10);
    check("R1 D0 at start", {16'b0, rd_w(8'h10)}, 32'h0000);
    check("R1 D1 next", {16'b0, rd_w(8'h12)}, 32'h1111);
    check("R2 A0 low half", {16'b0, rd_w(8'h14)}, 32'h8888);
    check("R10 no extra store", {16'b0, rd_w(8'h16)}, 32'h0);
    check("R10 access count", n_acc, 3);
    check("R9 R7 cycles", {16'b0, cycles_o}, 32'd20);
  endtask

  task automatic t_load_long_postinc();
    init_state();
    {mem[8'h40], mem[8'h41], mem[8'h42], mem[8'h43]} = 32'h11223344;
    {mem[8'h44], mem[8'h45], mem[8'h46], mem[8'h47]} = 32'h55667788;
    run(16'h0011, 1'b1, 1'b1, 3'd3, 3'd2, 32'h40);
    check("R1 D0 long", rf[0], 32'h11223344);
    check("R2 D4 long step", rf[4], 32'h55667788);
    check("R6 A2 writeback", rf[10], 32'h48);
    check("R8 R7 cycles", {16'b0, cycles_o}, 32'd28);
  endtask

  task automatic t_load_word_sext();
    init_state();
    {mem[8'h60], mem[8'h61]} = 16'h8001;
    {mem[8'h62], mem[8'h63]} = 16'h1234;
    run(16'h8002, 1'b0, 1'b1, 3'd5, 3'd0, 32'h60);
    check("R3 D1 sign ext", rf[1], 32'hFFFF8001);
    check("R3 A7 positive", rf[15], 32'h00001234);
    check("R8 mode5 cycles", {16'b0, cycles_o}, 32'd24);
  endtask

  task automatic t_predec();
    init_state();
    rf[14] = 32'h80;
    run(16'h8001, 1'b1, 1'b0, 3'd4, 3'd6, 32'h80);
    check("R4 first address", first_addr, 32'h7C);
    check("R4 A7 highest", rd_l(8'h7C), rf[15]);
    check("R4 D0 below", rd_l(8'h78), rf[0]);
    check("R5 A6 writeback", rf[14], 32'h78);
    check("R9 mode4 cycles", {16'b0, cycles_o}, 32'd24);
  endtask

  task automatic t_zero_mask();
    init_state();
    rf[11] = 32'h12345678;
    run(16'h0000, 1'b1, 1'b1, 3'd3, 3'd3, 32'h20);
    check("R10 no access", n_acc, 0);
    check("R10 base unchanged", rf[11], 32'h12345678);
    check("R10 base cost only", {16'b0, cycles_o}, 32'd12);
  endtask

  task automatic t_absolute();
    init_state();
    run(16'h0004, 1'b0, 1'b0, 3'd7, 3'd0, 32'hA0);
    check("R2 D2 word", {16'b0, rd_w(8'hA0)}, 32'h2222);
    check("R9 abs short store", {16'b0, cycles_o}, 32'd16);
    {mem[8'hB0], mem[8'hB1], mem[8'hB2], mem[8'hB3]} = 32'hCAFEF00D;
    run(16'h0001, 1'b1, 1'b1, 3'd7, 3'd1, 32'hB0);
    check("R8 abs long load data", rf[0], 32'hCAFEF00D);
    check("R8 abs long load cycles", {16'b0, cycles_o}, 32'd28);
    run(16'h0001, 1'b0, 1'b0, 3'd6, 3'd0, 32'hC8);
    check("R9 mode6 store", {16'b0, cycles_o}, 32'd18);
    run(16'h0000, 1'b1, 1'b1, 3'd6, 3'd0, 32'hC8);
    check("R8 mode6 load", {16'b0, cycles_o}, 32'd18);
  endtask

  task automatic t_wb_collision();
    init_state();
    {mem[8'hC0], mem[8'hC1]} = 16'h7FFF;
    run(16'h0400, 1'b0, 1'b1, 3'd3, 3'd2, 32'hC0);
    check("R6 writeback wins", rf[10], 32'hC2);
    check("R7 collision cycles", {16'b0, cycles_o}, 32'd16);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    init_state();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_store_word_asc();
    t_load_long_postinc();
    t_load_word_sext();
    t_predec();
    t_zero_mask();
    t_absolute();
    t_wb_collision();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule